// File: doc/BRIEF.md
# Soft power-on state controller

This block keeps the state of an active-low power-on output for a system that stays alive on standby power. A front-panel button and a pre-qualified wake request switch the system on, and the button can also switch it off. Three configuration bits set the policy. The block keeps these bits, and the current power state, in the battery-backed domain, so they survive a reset of the standby supply.

When the standby supply's reset arrives, two configuration bits choose what happens: force power on, force power off, or leave the output as it was. Setting both bits is illegal, and a write that attempts it is refused for those two bits. A third bit, which is set by default, controls whether the button may switch power off. The button input is qualified by a small counter. A press must stay high for a set number of cycles, and each press yields exactly one toggle however long it is held.

Top module: `softpwr_ctrl`

## Requirements
- R1: The battery-domain reset (`rst_bat_n_i` low at a clock edge) drives `pwr_on_n_o` to 1 (off) and sets the configuration readback to 3'b100: bit 0 (power up on standby reset) = 0, bit 1 (force off on standby reset) = 0, bit 2 (button power-off enable) = 1.
- R2: With bit 0 set, a clock edge with `stby_rst_n_i` low drives `pwr_on_n_o` to 0.
- R3: With bits 0 and 1 both clear, a standby reset leaves `pwr_on_n_o` at its previous value, whether that was on or off.
- R4: With bit 1 set, a clock edge with `stby_rst_n_i` low drives `pwr_on_n_o` to 1.
- R5: A configuration write with bits 0 and 1 both set leaves bits 0 and 1 at their old values and still updates bit 2.
- R6: `wake_i` high at a clock edge, with no standby reset, drives `pwr_on_n_o` to 0 at that edge.
- R7: A qualified button press while off drives `pwr_on_n_o` to 0.
- R8: A qualified button press while on, with bit 2 set, drives `pwr_on_n_o` to 1.
- R9: With bit 2 clear, a button press while on leaves `pwr_on_n_o` at 0.
- R10: A press counts only once `btn_i` has been high for `BTN_QUAL_CYCLES` consecutive edges (default 3), and it causes exactly one toggle however long the button is held. A shorter press has no effect.
- R11: A wake request and a press in the same cycle while on leave the output on, because wake takes priority.
- R12: While the standby reset is low, the configured standby action overrides both wake and button.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_bat_n_i | input | 1 | Battery-domain reset, synchronous, active low |
| stby_rst_n_i | input | 1 | Standby-supply reset, synchronous, active low |
| btn_i | input | 1 | Synchronized button level, high = pressed |
| wake_i | input | 1 | Pre-qualified wake request |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 3 | Configuration write data (bit 0 up-on-reset, bit 1 off-on-reset, bit 2 button-off enable) |
| pwr_on_n_o | output | 1 | Power-on output, 0 = system powered |
| cfg_rdata_o | output | 3 | Configuration readback, same bit layout |

## Verification
The assertions assume that `btn_i` and `wake_i` are already synchronous to `clk_i`. They also assume that the battery reset is applied before the standby reset is used, because every property is disabled while the battery reset is low. The stimulus changes every input on the falling edge and applies each reset for whole cycles. It also drops the wake request before the standby reset is released, so that each override seen in a cycle comes from one known cause. The bench tries the illegal configuration value on purpose and reports it as a flagged attempt.

// File: rtl/softpwr_pkg.sv
// Shared constants and types for the soft power-on controller.
// Assumes a three-bit configuration word whose bit positions are fixed here.
package softpwr_pkg;
    localparam int CFG_W   = 3;
    localparam int BIT_UP  = 0;  // power up on standby reset
    localparam int BIT_OFF = 1;  // force off on standby reset
    localparam int BIT_BEN = 2;  // button may switch power off

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ON   = 2'd1,
        ACT_OFF  = 2'd2,
        ACT_BAD  = 2'd3
    } stby_act_e;

    // Map the two standby-policy bits to an action.
    function automatic stby_act_e decode_act(input logic up, input logic off);
        case ({off, up})
            2'b01:   decode_act = ACT_ON;
            2'b10:   decode_act = ACT_OFF;
            2'b11:   decode_act = ACT_BAD;
            default: decode_act = ACT_HOLD;
        endcase
    endfunction
endpackage

// File: rtl/softpwr_cfg.sv
// Battery-backed configuration register for the standby policy and the button enable.
// Assumes writes are synchronous. A write that sets both standby bits keeps the old
// standby bits and still updates the enable bit.
module softpwr_cfg
    import softpwr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_bat_n_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic             up_o,
    output logic             off_o,
    output logic             ben_o,
    output stby_act_e        act_o
);
    logic up_q, off_q, ben_q;
    logic wr_bad;

    // Flag a write that asks for both standby actions at once.
    always_comb wr_bad = wdata_i[BIT_UP] && wdata_i[BIT_OFF];

    // Configuration storage with battery-domain defaults.
    always_ff @(posedge clk_i) begin
        if (!rst_bat_n_i) begin
            up_q  <= 1'b0;
            off_q <= 1'b0;
            ben_q <= 1'b1;
        end else if (wr_i) begin
            ben_q <= wdata_i[BIT_BEN];
            if (!wr_bad) begin
                up_q  <= wdata_i[BIT_UP];
                off_q <= wdata_i[BIT_OFF];
            end
        end
    end

    // Expose the stored bits and the decoded standby action.
    always_comb begin
        up_o  = up_q;
        off_o = off_q;
        ben_o = ben_q;
        act_o = decode_act(up_q, off_q);
    end

    // R5
    illegal_wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        wr_i && wdata_i[BIT_UP] && wdata_i[BIT_OFF] |=> $stable({up_q, off_q}));

    // R5
    wr_ben_take_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        wr_i |=> ben_q == $past(wdata_i[BIT_BEN]));
endmodule

// File: rtl/softpwr_btn_qual.sv
// Button qualifier: emits one pulse once the button has been high for QUAL_CYCLES edges.
// Assumes btn_i is synchronous. Lives in the standby domain and restarts on standby reset.
module softpwr_btn_qual #(
    parameter int QUAL_CYCLES = 3
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic btn_i,
    output logic press_o
);
    localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(QUAL_CYCLES);

    logic [CNT_W-1:0] cnt_q;

    // Pulse on the edge that completes the qualifying window.
    always_comb press_o = btn_i && (cnt_q == LAST);

    // Count consecutive high cycles, saturating until release.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i)         cnt_q <= '0;
        else if (!btn_i)      cnt_q <= '0;
        else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end

    // R10
    single_press_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        press_o |=> !press_o);

    // R10
    press_needs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !btn_i |=> !press_o || (QUAL_CYCLES == 1));
endmodule

// File: rtl/softpwr_state.sv
// Power state register in the battery domain. The standby reset applies the
// configured action. Otherwise wake forces on, and a press toggles, with
// turn-off gated by the enable. Assumes the action is never ACT_BAD.
module softpwr_state
    import softpwr_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_bat_n_i,
    input  logic      stby_rst_n_i,
    input  logic      wake_i,
    input  logic      press_i,
    input  logic      ben_i,
    input  stby_act_e act_i,
    output logic      pwr_on_o
);
    logic on_q;

    // Select the next power state by priority: battery reset, standby action, wake, button.
    always_ff @(posedge clk_i) begin
        if (!rst_bat_n_i) begin
            on_q <= 1'b0;
        end else if (!stby_rst_n_i) begin
            case (act_i)
                ACT_ON:  on_q <= 1'b1;
                ACT_OFF: on_q <= 1'b0;
                default: on_q <= on_q;
            endcase
        end else if (wake_i) begin
            on_q <= 1'b1;
        end else if (press_i) begin
            if (!on_q)     on_q <= 1'b1;
            else if (ben_i) on_q <= 1'b0;
        end
    end

    always_comb pwr_on_o = on_q;

    // R2
    stby_up_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        !stby_rst_n_i && act_i == ACT_ON |=> on_q);

    // R4 R12
    stby_off_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        !stby_rst_n_i && act_i == ACT_OFF |=> !on_q);

    // R3
    stby_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        !stby_rst_n_i && act_i == ACT_HOLD |=> $stable(on_q));

    // R6 R11
    wake_on_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        stby_rst_n_i && wake_i |=> on_q);

    // R9
    btn_off_block_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        stby_rst_n_i && on_q && !ben_i |=> on_q);

    // R5
    no_bad_act_chk: assert property (@(posedge clk_i) disable iff (!rst_bat_n_i)
        act_i != ACT_BAD);
endmodule

// File: rtl/softpwr_ctrl.sv
// Top of the soft power-on controller: configuration, button qualifier and power state.
// Assumes all inputs are synchronous to clk_i and both resets are synchronous, active low.
module softpwr_ctrl
    import softpwr_pkg::*;
#(
    parameter int BTN_QUAL_CYCLES = 3
) (
    input  logic             clk_i,
    input  logic             rst_bat_n_i,
    input  logic             stby_rst_n_i,
    input  logic             btn_i,
    input  logic             wake_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             pwr_on_n_o,
    output logic [CFG_W-1:0] cfg_rdata_o
);
    logic      up, off, ben, press, pwr_on;
    logic      btn_rst_n;
    stby_act_e act;

    // The button logic restarts on either reset.
    always_comb btn_rst_n = rst_bat_n_i && stby_rst_n_i;

    softpwr_cfg cfg_i (
        .clk_i       (clk_i),
        .rst_bat_n_i (rst_bat_n_i),
        .wr_i        (cfg_wr_i),
        .wdata_i     (cfg_wdata_i),
        .up_o        (up),
        .off_o       (off),
        .ben_o       (ben),
        .act_o       (act)
    );

    softpwr_btn_qual #(.QUAL_CYCLES(BTN_QUAL_CYCLES)) btn_i_q (
        .clk_i   (clk_i),
        .rst_n_i (btn_rst_n),
        .btn_i   (btn_i),
        .press_o (press)
    );

    softpwr_state state_i (
        .clk_i        (clk_i),
        .rst_bat_n_i  (rst_bat_n_i),
        .stby_rst_n_i (stby_rst_n_i),
        .wake_i       (wake_i),
        .press_i      (press),
        .ben_i        (ben),
        .act_i        (act),
        .pwr_on_o     (pwr_on)
    );

    // Drive the active-low pin and assemble the readback word.
    always_comb begin
        pwr_on_n_o           = !pwr_on;
        cfg_rdata_o          = '0;
        cfg_rdata_o[BIT_UP]  = up;
        cfg_rdata_o[BIT_OFF] = off;
        cfg_rdata_o[BIT_BEN] = ben;
    end

    // R1
    bat_reset_off_chk: assert property (@(posedge clk_i)
        !rst_bat_n_i |=> pwr_on_n_o && cfg_rdata_o == 3'b100);
endmodule

// File: tb/softpwr_ctrl_tb_top.sv
// Directed bench for softpwr_ctrl: one task per scenario, each checking its own results.
module softpwr_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_bat_n = 1'b0;
    logic       stby_rst_n = 1'b1;
    logic       btn = 1'b0;
    logic       wake = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [2:0] cfg_wdata = 3'b000;
    logic       pwr_on_n;
    logic [2:0] cfg_rdata;
    int         n_checks = 0;
    int         n_errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    softpwr_ctrl #(.BTN_QUAL_CYCLES(3)) dut_i (
        .clk_i        (clk),
        .rst_bat_n_i  (rst_bat_n),
        .stby_rst_n_i (stby_rst_n),
        .btn_i        (btn),
        .wake_i       (wake),
        .cfg_wr_i     (cfg_wr),
        .cfg_wdata_i  (cfg_wdata),
        .pwr_on_n_o   (pwr_on_n),
        .cfg_rdata_o  (cfg_rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bat_reset();
        @(negedge clk); rst_bat_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_bat_n = 1'b1;
        check("R1 pin", pwr_on_n, 1);
        check("R1 cfg", cfg_rdata, 3'b100);
    endtask

    task automatic write_cfg(input logic [2:0] d);
        @(negedge clk);
        if (d[0] && d[1]) $display("NOTE: illegal standby configuration %b attempted", d);
        cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic stby_pulse(input logic wake_during);
        @(negedge clk); stby_rst_n = 1'b0; wake = wake_during;
        @(negedge clk); stby_rst_n = 1'b1; wake = 1'b0;
    endtask

    task automatic do_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic press(input int n);
        @(negedge clk); btn = 1'b1;
        for (int i = 1; i < n; i++) @(negedge clk);
        @(negedge clk); btn = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wake_and_buttons();
        do_wake();           check("R6 wake on", pwr_on_n, 0);
        press(3);            check("R8 press off", pwr_on_n, 1);
        press(2);            check("R10 short press ignored", pwr_on_n, 1);
        press(3);            check("R7 press on", pwr_on_n, 0);
        press(10);           check("R10 long press one toggle", pwr_on_n, 1);
    endtask

    task automatic t_stby_policies();
        write_cfg(3'b100);
        stby_pulse(1'b0);    check("R3 hold off", pwr_on_n, 1);
        do_wake();
        stby_pulse(1'b0);    check("R3 hold on", pwr_on_n, 0);
        write_cfg(3'b101);
        press(3);            check("R8 off before up", pwr_on_n, 1);
        stby_pulse(1'b0);    check("R2 up on reset", pwr_on_n, 0);
        write_cfg(3'b110);
        stby_pulse(1'b0);    check("R4 off on reset", pwr_on_n, 1);
    endtask

    task automatic t_illegal_cfg();
        write_cfg(3'b111);   check("R5 both bits refused", cfg_rdata, 3'b110);
        write_cfg(3'b011);   check("R5 enable still written", cfg_rdata, 3'b010);
    endtask

    task automatic t_button_disable();
        write_cfg(3'b000);
        do_wake();
        press(3);            check("R9 press blocked", pwr_on_n, 0);
    endtask

    task automatic t_priorities();
        write_cfg(3'b100);
        @(negedge clk); wake = 1'b1; btn = 1'b1;
        @(negedge clk); @(negedge clk); @(negedge clk);
        wake = 1'b0; btn = 1'b0;
        @(negedge clk);      check("R11 wake beats press", pwr_on_n, 0);
        write_cfg(3'b110);
        stby_pulse(1'b1);    check("R12 reset beats wake", pwr_on_n, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        bat_reset();
        t_wake_and_buttons();
        t_stby_policies();
        t_illegal_cfg();
        t_button_disable();
        t_priorities();
        do_wake();
        bat_reset();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule